// File: doc/BRIEF.md
# Watchdog and Periodic Interrupt Timer

This block holds two down-counters that share one 16-bit control word: a periodic interrupt timer and a watchdog. Both are clocked by the system clock and advance only on cycles where the reference tick enable is high and the run bit of the control word is set. The periodic timer issues a one-cycle interrupt pulse each time its count passes zero. The watchdog needs its own enable bit as well as the run bit. It counts through a selectable prescaler (divide by 8 or by 64) and raises a one-cycle reset request if software stops servicing it. An external debug-hold input freezes the watchdog.

The control word is protected. A write to it takes effect only when it directly follows a two-value unlock sequence on a separate key register, and each unlock permits one write. Software services the watchdog by writing a two-value sequence to a service register. The bus side is a plain single-cycle register port with no handshake, because every access completes in the cycle it is presented.

Top module: `wdt_rti_timer`

## Requirements
- R1: After reset the control word reads 0x0000 and both `irq_pulse` and `wd_reset_req` are low.
- R2: The control word at address 0 has these fields: bit 15 watchdog enable, bit 14 watchdog prescale select, bits 13:12 reserved, bit 11 run enable, bits 10:8 spare storage, bits 7:0 divider D. Bits 13:12 always read 0. Bits 10:8 read back the value written. Reads at addresses 1, 2 and 3 return 0.
- R3: Writing 0x5555 and then 0xAAAA to the key register (address 1) arms the unlock. The next bus access, if it is a write to address 0, is committed. Exactly one write is committed per unlock.
- R4: A control write without a complete unlock directly before it is ignored. This covers a key value out of order and any bus access between the unlock and the write.
- R5: With the run bit set and the tick enable high, `irq_pulse` goes high for one cycle on the (D+1)-th tick after a committed control write, and then every D+1 ticks.
- R6: With the run bit clear, neither counter advances, so neither output pulses, even if the watchdog enable is set.
- R7: With the watchdog enable and run bits both set, `wd_reset_req` pulses for one cycle (D+1)*P ticks after a committed control write or a service reload. P is 8 when bit 14 is 0 and 64 when bit 14 is 1.
- R8: While `dbg_hold` is high the watchdog counter and prescaler are frozen. Counting resumes from the held value when `dbg_hold` is released.
- R9: Writing 0x5555 and then 0xAAAA to the service register (address 2) reloads the watchdog counter and prescaler. Any other write to that register between the two values cancels the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 key, 2 service |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the read |
| tick_en | input | 1 | Reference clock enable for both timers |
| dbg_hold | input | 1 | External debug hold, stops the watchdog |
| irq_pulse | output | 1 | One-cycle periodic interrupt request |
| wd_reset_req | output | 1 | One-cycle watchdog reset request |

## Verification
The periodic timer is measured with a small divider. The bench checks first-pulse latency, pulse width and the period between pulses, which separates an off-by-one reload from a correct D+1 period. The watchdog is timed under both prescale settings, so a swapped or ignored select bit shows up as a factor-of-eight error. The protected write is tried with a clean unlock, a missing unlock, a reordered key, an intervening read and a second write after one commit, and the spare and reserved bits tell storage from masking. Service, broken-service, debug-hold and run-disabled patterns each shift or suppress the expected reset time by a known number of cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W  = 16;
  localparam int DIV_W  = 8;
  localparam int PRE_LO = 8;
  localparam int PRE_HI = 64;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_KEY  = 2'd1;
  localparam logic [1:0] ADDR_SVC  = 2'd2;

  localparam logic [REG_W-1:0] SEQ_FIRST  = 16'h5555;
  localparam logic [REG_W-1:0] SEQ_SECOND = 16'hAAAA;

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} unlock_e;

  typedef struct packed {
    logic             wd_en;
    logic             wd_slow;
    logic [1:0]       rsv;
    logic             run_en;
    logic [2:0]       spare;
    logic [DIV_W-1:0] div;
  } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             run_en_o,
  output logic             wd_en_o,
  output logic             wd_slow_o,
  output logic [DIV_W-1:0] div_next_o,
  output logic             commit_o,
  output logic             svc_reload_o
);
  ctrl_t   ctrl_q, ctrl_d;
  unlock_e ul_q, ul_d;
  logic    svc_half_q;

  logic access, ctrl_wr, key_wr, svc_wr;
  assign access  = sel_i & (wr_i | rd_i);
  assign ctrl_wr = sel_i & wr_i & (addr_i == ADDR_CTRL);
  assign key_wr  = sel_i & wr_i & (addr_i == ADDR_KEY);
  assign svc_wr  = sel_i & wr_i & (addr_i == ADDR_SVC);

  always_comb begin
    ul_d = ul_q;
    case (ul_q)
      UL_IDLE: if (key_wr && wdata_i == SEQ_FIRST) ul_d = UL_HALF;
      UL_HALF: if (access) ul_d = (key_wr && wdata_i == SEQ_SECOND) ? UL_OPEN : UL_IDLE;
      UL_OPEN: if (access) ul_d = UL_IDLE;
      default: ul_d = UL_IDLE;
    endcase
  end

  assign commit_o = (ul_q == UL_OPEN) & ctrl_wr;

  always_comb begin
    ctrl_d = ctrl_q;
    if (commit_o) begin
      ctrl_d     = ctrl_t'(wdata_i);
      ctrl_d.rsv = 2'b00;
    end
  end

  assign svc_reload_o = svc_wr & svc_half_q & (wdata_i == SEQ_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      ul_q       <= UL_IDLE;
      svc_half_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ul_q   <= ul_d;
      if (svc_wr) svc_half_q <= (wdata_i == SEQ_FIRST);
    end
  end

  assign rdata_o    = (sel_i & rd_i & (addr_i == ADDR_CTRL)) ? ctrl_q : '0;
  assign run_en_o   = ctrl_q.run_en;
  assign wd_en_o    = ctrl_q.wd_en;
  assign wd_slow_o  = ctrl_q.wd_slow;
  assign div_next_o = ctrl_d.div;

  // R4: a control write without an open unlock leaves the word untouched
  p_locked_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ul_q != UL_OPEN) |=> $stable(ctrl_q));
  // R3: a commit consumes the unlock
  p_single_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (ul_q == UL_IDLE));
  // R2: reserved bits never hold a one
  p_rsv_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commit_o) |=> (ctrl_q.rsv == 2'b00));
endmodule

// File: rtl/wdt_rti.sv
module wdt_rti #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             irq_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             irq_q;
  logic             at_zero;
  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= tick_i & ~load_i & at_zero;
      if (load_i)      cnt_q <= div_i;
      else if (tick_i) cnt_q <= at_zero ? div_i : cnt_q - 1'b1;
    end
  end

  assign irq_o = irq_q;

  // R5: a pulse only follows an enabled tick
  p_irq_from_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(tick_i));
  // R6: without a tick or load the count holds
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_cop.sv
module wdt_cop #(
  parameter int DIV_W  = 8,
  parameter int PRE_LO = 8,
  parameter int PRE_HI = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             slow_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             req_o
);
  localparam int PW = $clog2(PRE_HI);
  localparam logic [PW-1:0] LIM_LO = PW'(PRE_LO - 1);
  localparam logic [PW-1:0] LIM_HI = PW'(PRE_HI - 1);

  logic [PW-1:0]    pre_q;
  logic [DIV_W-1:0] cnt_q;
  logic             req_q;
  logic [PW-1:0]    limit;
  logic             step;

  assign limit = slow_i ? LIM_HI : LIM_LO;
  assign step  = tick_i & (pre_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= step & ~load_i & (cnt_q == '0);
      if (load_i) begin
        pre_q <= '0;
        cnt_q <= div_i;
      end else if (tick_i) begin
        pre_q <= step ? '0 : pre_q + 1'b1;
        if (step) cnt_q <= (cnt_q == '0) ? div_i : cnt_q - 1'b1;
      end
    end
  end

  assign req_o = req_q;

  // R7: the prescaler never runs past its selected limit
  p_pre_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_q <= limit));
  // R7: the reset request lasts one cycle
  p_req_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);
  // R8: a held watchdog keeps both counts
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> ($stable(cnt_q) && $stable(pre_q)));
endmodule

// File: rtl/wdt_rti_timer.sv
module wdt_rti_timer
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             tick_en,
  input  logic             dbg_hold,
  output logic             irq_pulse,
  output logic             wd_reset_req
);
  logic             run_en, wd_en, wd_slow, commit, svc_reload;
  logic [DIV_W-1:0] div_next;
  logic             tick_run, tick_wd;

  wdt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sel_i(bus_sel), .wr_i(bus_wr), .rd_i(bus_rd),
    .addr_i(bus_addr), .wdata_i(bus_wdata), .rdata_o(bus_rdata),
    .run_en_o(run_en), .wd_en_o(wd_en), .wd_slow_o(wd_slow),
    .div_next_o(div_next), .commit_o(commit), .svc_reload_o(svc_reload)
  );

  // shared gate: the run bit feeds both timers
  assign tick_run = tick_en & run_en;
  assign tick_wd  = tick_run & wd_en & ~dbg_hold;

  wdt_rti #(.DIV_W(DIV_W)) u_rti (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_run), .load_i(commit),
    .div_i(div_next), .irq_o(irq_pulse)
  );

  wdt_cop #(.DIV_W(DIV_W), .PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) u_cop (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_wd), .slow_i(wd_slow),
    .load_i(commit | svc_reload), .div_i(div_next), .req_o(wd_reset_req)
  );

  // R7/R8: a reset request needs both enables, a tick and no debug hold
  p_wd_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset_req |-> $past(tick_en && run_en && wd_en && !dbg_hold));
  // R6: run disabled means no interrupt next cycle
  p_run_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !irq_pulse);
endmodule

// File: tb/tb_wdt_rti_timer.sv
`timescale 1ns/1ps
module tb_wdt_rti_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tick_en = 1'b1, dbg_hold = 1'b0;
  logic        irq_pulse, wd_reset_req;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  wdt_rti_timer dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic unlock_write(input logic [15:0] d);
    wr(2'd1, 16'h5555); wr(2'd1, 16'hAAAA); wr(2'd0, d);
  endtask

  // edges until signal is seen high, 0 if not within limit
  task automatic wait_irq(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (irq_pulse) begin n = i; break; end
    end
  endtask

  task automatic wait_rst(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (wd_reset_req) begin n = i; break; end
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(2'd0, v);
    check("R1 ctrl reset", v, 16'h0000);
    check("R1 irq low", irq_pulse, 1'b0);
    check("R1 reset req low", wd_reset_req, 1'b0);
  endtask

  task automatic t_lock;
    logic [15:0] v;
    wr(2'd0, 16'hFFFF); rd(2'd0, v);
    check("R4 write without unlock", v, 16'h0000);
    wr(2'd1, 16'hAAAA); wr(2'd1, 16'h5555); wr(2'd0, 16'h0801); rd(2'd0, v);
    check("R4 key out of order", v, 16'h0000);
    wr(2'd1, 16'h5555); wr(2'd1, 16'hAAAA); rd(2'd0, v); wr(2'd0, 16'h0801); rd(2'd0, v);
    check("R4 access between unlock and write", v, 16'h0000);
  endtask

  task automatic t_readback;
    logic [15:0] v;
    unlock_write(16'h7755); rd(2'd0, v);
    check("R2 R3 read-back, reserved zero, spare kept", v, 16'h4755);
    wr(2'd0, 16'h0000); rd(2'd0, v);
    check("R3 one write per unlock", v, 16'h4755);
    rd(2'd1, v);
    check("R2 key address reads zero", v, 16'h0000);
  endtask

  task automatic t_rti;
    int n;
    unlock_write(16'h0804);
    wait_irq(50, n); check("R5 first pulse latency", n, 5);
    @(negedge clk); check("R5 pulse width", irq_pulse, 1'b0);
    wait_irq(50, n); check("R5 period", n, 4);
    wait_rst(100, n); check("R7 no reset with watchdog off", n, 0);
  endtask

  task automatic t_run_off;
    int n;
    unlock_write(16'h8003);
    wait_irq(300, n); check("R6 no irq with run off", n, 0);
    wait_rst(300, n); check("R6 no reset with run off", n, 0);
  endtask

  task automatic t_wd;
    int n;
    unlock_write(16'h8803);
    wait_rst(200, n); check("R7 timeout prescale 8", n, 32);
    @(negedge clk); check("R7 reset pulse width", wd_reset_req, 1'b0);
    unlock_write(16'hC801);
    wait_rst(400, n); check("R7 timeout prescale 64", n, 128);
  endtask

  task automatic t_dbg;
    int n;
    dbg_hold = 1'b1;
    unlock_write(16'h8801);
    wait_rst(100, n); check("R8 frozen under debug hold", n, 0);
    dbg_hold = 1'b0;
    wait_rst(100, n); check("R8 resume from held value", n, 16);
  endtask

  task automatic t_svc;
    int n;
    unlock_write(16'h8803);
    repeat (20) @(negedge clk);
    wr(2'd2, 16'h5555); wr(2'd2, 16'hAAAA);
    wait_rst(100, n); check("R9 service reloads watchdog", n, 32);
    unlock_write(16'h8803);
    repeat (10) @(negedge clk);
    wr(2'd2, 16'h5555); wr(2'd2, 16'h1234); wr(2'd2, 16'hAAAA);
    wait_rst(100, n); check("R9 broken service sequence ignored", n, 19);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_readback();
    t_rti();
    t_run_off();
    t_wd();
    t_dbg();
    t_svc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule